// File: doc/BRIEF.md
# Write-Once Timed-Event Clock Divider

This block turns a fast oscillator clock into a one-cycle clock-enable tick at a slow, programmable rate. It is meant for timed operations such as nonvolatile-memory program and erase sequencing. Software sets the rate by writing a single 8-bit control register on a simple synchronous register bus.

The control register has three parts. A 6-bit divide field selects a main divider ratio of field+1. An enable bit places a fixed divide-by-8 prescaler ahead of that divider. A read-only flag reports whether the register has been configured.

The rate can be set exactly once after reset. The first write to the control address locks the settings, and the flag stays set until the next reset. The tick stays low until that write has happened, so no timed event can run from an unconfigured divider. Two reserved addresses read as zero and ignore writes.

Top module: `wo_clk_div`

## Requirements
- R1: After reset, a read of the control register (address 0) returns 0x00 and `tick` is low.
- R2: The first write to address 0 after reset latches write-data bit 6 as the prescaler enable and bits 5:0 as the divide field. A later read of address 0 returns bit 7 = 1, bit 6 = the enable, and bits 5:0 = the field.
- R3: Every write to address 0 after the first is ignored until the next reset. The readback value and the tick rate both stay unchanged.
- R4: Bit 7 of the write data has no effect. Any first write sets the flag, and a first write of 0x80 reads back as 0x80.
- R5: With the prescaler disabled, ticks repeat every field+1 clock cycles.
- R6: With the prescaler enabled, ticks repeat every 8×(field+1) cycles. Field 63 with the prescaler on gives the maximum ratio of 512.
- R7: When the total ratio is greater than 1, each tick is high for exactly one cycle. With a ratio of 1, `tick` stays high on every cycle.
- R8: `tick` stays low while the register has not been written since reset.
- R9: Addresses 1 and 2 are reserved, and address 3 is unmapped. All three read 0x00. Writes to them change neither the flag nor the settings.
- R10: With a total ratio N, the first tick is seen high N clock edges after the edge that captures the configuring write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| tick | output | 1 | Divided clock-enable pulse |

## Verification
The read path is combinational, so the bench checks readback a short delay after changing `addr`, without waiting for a clock edge. A write takes effect at the edge that captures it. From that edge, the first tick is due exactly N edges later, where N is the total ratio, and the next ticks follow every N edges. The bench drives and samples on falling edges and counts falling edges from the one just after the write edge. It checks the first-tick latency, two full periods and the low cycle that follows each pulse against ratios it computes from the field and the prescaler bit.

// File: rtl/wo_clk_div.sv
module wo_clk_div #(
  parameter int DIV_W = 6,
  parameter int PRE_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       tick
);
  localparam logic [1:0] CTRL_ADDR = 2'd0;
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic             loaded;
  logic             pre_en;
  logic [DIV_W-1:0] div_sel;
  logic [DIV_W-1:0] div_cnt;
  logic [PRE_W-1:0] pre_cnt;
  logic             tick_q;

  wire ctrl_wr  = wr_en && (addr == CTRL_ADDR);
  wire pre_wrap = !pre_en || (pre_cnt == PRE_LAST);
  wire div_wrap = (div_cnt == div_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded  <= 1'b0;
      pre_en  <= 1'b0;
      div_sel <= '0;
      div_cnt <= '0;
      pre_cnt <= '0;
      tick_q  <= 1'b0;
    end else begin
      if (ctrl_wr && !loaded) begin
        loaded  <= 1'b1;
        pre_en  <= wdata[6];
        div_sel <= wdata[DIV_W-1:0];
        pre_cnt <= '0;
        div_cnt <= '0;
      end else if (loaded) begin
        if (pre_en) pre_cnt <= pre_cnt + 1'b1;
        if (pre_wrap) div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
      end
      tick_q <= loaded && pre_wrap && div_wrap;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == CTRL_ADDR) begin
      rdata[7] = loaded;
      rdata[6] = pre_en;
      rdata[DIV_W-1:0] = div_sel;
    end
  end

  assign tick = tick_q;

  p_no_tick_unloaded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded |-> !tick);
  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);
  p_settings_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> ($stable(div_sel) && $stable(pre_en)));
  p_div_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= div_sel);
  p_pre_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_en |-> (pre_cnt == '0));
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (pre_en || div_sel != '0)) |=> !tick);
  p_reserved_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != CTRL_ADDR && !loaded) |=> !loaded);
endmodule

// File: tb/tb_wo_clk_div.sv
module tb_wo_clk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tick;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  wo_clk_div dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                  .wdata(wdata), .rdata(rdata), .tick(tick));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; addr = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = 2'd0;
  endtask

  task automatic expect_quiet(input string req, input int n);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick) highs++;
    end
    check(highs == 0, req, highs, 0);
  endtask

  // call right after bus_write returns
  task automatic measure(input int ratio, input string req);
    int n = 0;
    if (ratio == 1) begin
      int highs = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (tick) highs++;
      end
      check(highs == 8, {req, " R7 continuous"}, highs, 8);
      return;
    end
    do begin @(negedge clk); n++; end while (!tick && n < 1100);
    check(n == ratio, "R10 first tick latency", n, ratio);
    for (int p = 0; p < 2; p++) begin
      n = 0;
      do begin
        @(negedge clk); n++;
        if (n == 1) check(!tick, "R7 pulse width", tick, 0);
      end while (!tick && n < 1100);
      check(n == ratio, req, n, ratio);
    end
  endtask

  task automatic t_ratio(input logic [7:0] val);
    logic [7:0] rd;
    int ratio;
    ratio = (val[5:0] + 1) * (val[6] ? 8 : 1);
    do_reset();
    bus_write(2'd0, val);
    bus_read(2'd0, rd);
    check(rd == {1'b1, val[6:0]}, "R2 readback", rd, {1'b1, val[6:0]});
    measure(ratio, val[6] ? "R6 period prescaled" : "R5 period direct");
  endtask

  task automatic t_reset_state();
    logic [7:0] rd;
    do_reset();
    bus_read(2'd0, rd);
    check(rd == 8'h00, "R1 reset readback", rd, 0);
    check(tick == 1'b0, "R1 reset tick", tick, 0);
    expect_quiet("R8 no tick before load", 40);
  endtask

  task automatic t_reserved();
    logic [7:0] rd;
    do_reset();
    bus_write(2'd1, 8'hFF);
    bus_write(2'd2, 8'hFF);
    bus_write(2'd3, 8'hFF);
    for (int a = 1; a < 4; a++) begin
      bus_read(a[1:0], rd);
      check(rd == 8'h00, "R9 reserved reads zero", rd, 0);
    end
    bus_read(2'd0, rd);
    check(rd == 8'h00, "R9 reserved write leaves control", rd, 0);
    expect_quiet("R8 R9 still unloaded", 20);
  endtask

  task automatic t_second_write();
    logic [7:0] rd;
    do_reset();
    bus_write(2'd0, 8'h02);
    bus_write(2'd0, 8'h7F);
    bus_read(2'd0, rd);
    check(rd == 8'h82, "R3 second write ignored", rd, 8'h82);
    n_period3();
  endtask

  task automatic n_period3();
    int n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 1100);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 1100);
    check(n == 3, "R3 rate unchanged", n, 3);
  endtask

  task automatic t_bit7();
    logic [7:0] rd;
    do_reset();
    bus_write(2'd0, 8'h80);
    bus_read(2'd0, rd);
    check(rd == 8'h80, "R4 bit7 write", rd, 8'h80);
    do_reset();
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, rd);
    check(rd == 8'h80, "R4 flag from zero write", rd, 8'h80);
  endtask

  initial begin
    t_reset_state();
    t_reserved();
    t_bit7();
    t_ratio(8'h00);
    t_ratio(8'h05);
    t_ratio(8'h3F);
    t_ratio(8'h40);
    t_ratio(8'h43);
    t_ratio(8'h7F);
    t_second_write();
    finish_run();
  end
endmodule